// File: doc/BRIEF.md
# Sv32 Two-Level Page Table Walker

This block turns one virtual address into a physical address under the 32-bit, two-level paging scheme. It serves one request at a time. A request carries the virtual address, the access kind, the current privilege, the status bits that affect translation, the paging enable and the root table page number. The walker reads page-table entries through a single-beat memory port. When a leaf entry lacks its accessed flag, or lacks its dirty flag on a store, the walker updates the entry with a compare-and-swap on that port. The result comes back as a one-cycle response: either a physical address with read, write and execute rights, or a fault with its cause code and the faulting virtual address.

Machine-mode accesses and accesses with paging disabled skip the walk. When machine mode has its modify-privilege bit set, loads and stores are translated with the previous-privilege field instead, while fetches keep machine privilege. A superpage leaf at the upper level maps a 4 MiB region. Its low physical page bits must be zero, and the lower virtual page index fills them in.

Top module: `sv32_walker`

## Requirements
- R1: The effective privilege is req_priv_i, except for a load or store issued with req_priv_i=3 (machine) and req_mprv_i=1, which uses req_mpp_i. Fetches never substitute. Privilege codes: 0 user, 1 supervisor, 3 machine. Access codes on req_acc_i: 0 fetch, 1 load, 2 store.
- R2: When the effective privilege is machine or req_paging_i=0, there is no memory access. The response is asserted in the cycle after acceptance with rsp_paddr_o equal to the zero-extended virtual address and read, write and execute all set.
- R3: The first entry read is at root_ppn*4096 + VA[31:22]*4. After a pointer entry (V=1 with R, W and X all clear), the next read is at ppn*4096 + VA[21:12]*4. Entry bits: V0 R1 W2 X3 U4 G5 A6 D7, page number in bits 31:10.
- R4: An entry with V=0, or with W=1 and R=0, gives a page fault. A pointer entry read at the lower level also gives a page fault.
- R5: A leaf with U=1 faults under supervisor privilege unless req_sum_i=1. A leaf with U=0 faults under any effective privilege other than supervisor.
- R6: A fetch needs X. A load needs R, or needs X when req_mxr_i=1. A store needs both R and W. Any other combination gives a page fault.
- R7: A leaf that passes its checks but has A=0, or has D=0 on a store, is updated with a compare-and-swap. The port carries mem_we_o=1, mem_cmp_o set to the entry read, and mem_wdata_o set to that entry with A set, plus D on a store. The memory returns the prior word on mem_rdata_i and stores the new value only if the prior word matched.
- R8: If the word returned by the swap differs from mem_cmp_o, the walk starts over from the root. If the swap ends with mem_err_i, the result is a page fault.
- R9: For an upper-level leaf, the physical page's low 10 bits come from VA[21:12]. If the leaf's low 10 page bits are not zero, the result is a page fault.
- R10: rsp_w_o is set only if the leaf has W and either the access is a store or D is already set. rsp_r_o and rsp_x_o copy R and X.
- R11: The page fault cause is 12, 13 or 15 for fetch, load or store. A read that ends with mem_err_i gives the access fault cause 1, 5 or 7. On a fault, rsp_tval_o holds the virtual address, and the address and rights outputs are zero.
- R12: req_ready_o is high only while idle. rsp_valid_o lasts one cycle. mem_req_o, mem_addr_o and mem_we_o hold steady until mem_rsp_valid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | 32 | Virtual address |
| req_acc_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_priv_i | input | 2 | Current privilege |
| req_mprv_i | input | 1 | Modify-privilege bit |
| req_mpp_i | input | 2 | Previous privilege field |
| req_sum_i | input | 1 | Supervisor may touch user pages |
| req_mxr_i | input | 1 | Executable pages readable |
| req_paging_i | input | 1 | 1 = two-level paging, 0 = bare |
| req_root_ppn_i | input | 22 | Root table page number |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = compare-and-swap, 0 = read |
| mem_addr_o | output | 34 | Physical byte address of entry |
| mem_wdata_o | output | 32 | Swap new value |
| mem_cmp_o | output | 32 | Swap expected value |
| mem_rsp_valid_i | input | 1 | Memory response |
| mem_rdata_i | input | 32 | Read data, or prior word for a swap |
| mem_err_i | input | 1 | Access could not be performed |
| rsp_valid_o | output | 1 | Result valid for one cycle |
| rsp_fault_o | output | 1 | Translation faulted |
| rsp_cause_o | output | 4 | Fault cause code |
| rsp_tval_o | output | 32 | Faulting virtual address |
| rsp_paddr_o | output | 34 | Physical address |
| rsp_r_o | output | 1 | Read allowed |
| rsp_w_o | output | 1 | Write allowed |
| rsp_x_o | output | 1 | Execute allowed |

## Verification
The hardest case to reach is a swap whose entry changed between the read and the write, since a single-master bench never makes that happen on its own. The bench memory can be armed to flip a bit of the target word just before it services the swap. The design must then re-read both levels from the root, and then issue a second swap whose compare value is the modified word. A memory error on the swap and a memory error on a read are also injected at chosen word addresses, and response latency is stretched for some requests so that the port must hold its request steady.

// File: rtl/sv32_pkg.sv
package sv32_pkg;
  localparam int VA_W      = 32;
  localparam int PA_W      = 34;
  localparam int PTE_W     = 32;
  localparam int PAGE_BITS = 12;
  localparam int IDX_BITS  = 10;
  localparam int LEVELS    = 2;
  localparam int PTE_BYTES = 4;
  localparam int PPN_W     = PA_W - PAGE_BITS;
  localparam int VPN_W     = VA_W - PAGE_BITS;
  localparam int LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int PTE_SH    = $clog2(PTE_BYTES);
  localparam int PPN_LSB   = 10;

  localparam int B_V = 0, B_R = 1, B_W = 2, B_X = 3, B_U = 4, B_A = 6, B_D = 7;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef enum logic [1:0] {ACC_FETCH = 2'd0, ACC_LOAD = 2'd1, ACC_STORE = 2'd2} acc_e;

  function automatic logic [3:0] fault_cause(acc_e a, logic page);
    case (a)
      ACC_FETCH: return page ? 4'd12 : 4'd1;
      ACC_LOAD:  return page ? 4'd13 : 4'd5;
      default:   return page ? 4'd15 : 4'd7;
    endcase
  endfunction
endpackage

// File: rtl/sv32_mode_sel.sv
module sv32_mode_sel import sv32_pkg::*; (
  input  logic [1:0] priv_i,
  input  acc_e       acc_i,
  input  logic       mprv_i,
  input  logic [1:0] mpp_i,
  input  logic       paging_i,
  output logic [1:0] eff_priv_o,
  output logic       bypass_o
);
  always_comb begin
    eff_priv_o = priv_i;
    if (priv_i == PRIV_M && acc_i != ACC_FETCH && mprv_i) eff_priv_o = mpp_i;
    bypass_o = (eff_priv_o == PRIV_M) || !paging_i;
  end
endmodule

// File: rtl/sv32_pte_eval.sv
module sv32_pte_eval import sv32_pkg::*; (
  input  logic [PTE_W-1:0] pte_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [1:0]       eff_priv_i,
  input  acc_e             acc_i,
  input  logic             sum_i,
  input  logic             mxr_i,
  input  logic [VA_W-1:0]  vaddr_i,
  output logic             is_ptr_o,
  output logic             leaf_bad_o,
  output logic             need_ad_o,
  output logic [PTE_W-1:0] upd_pte_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             r_o,
  output logic             w_o,
  output logic             x_o
);
  logic v, r, w, x, u, a, d, store;
  logic [PPN_W-1:0] ppn, vpn, low_mask;
  logic bad_basic, bad_priv, bad_perm, misalign;

  assign v = pte_i[B_V];
  assign r = pte_i[B_R];
  assign w = pte_i[B_W];
  assign x = pte_i[B_X];
  assign u = pte_i[B_U];
  assign a = pte_i[B_A];
  assign d = pte_i[B_D];
  assign store = (acc_i == ACC_STORE);
  assign ppn = pte_i[PPN_LSB +: PPN_W];
  assign vpn = {{(PPN_W-VPN_W){1'b0}}, vaddr_i[VA_W-1:PAGE_BITS]};

  always_comb begin
    for (int i = 0; i < PPN_W; i++) low_mask[i] = (i < int'(lvl_i) * IDX_BITS);
  end

  always_comb begin
    is_ptr_o  = v && !r && !w && !x;
    bad_basic = !v || (w && !r);
    bad_priv  = u ? (eff_priv_i == PRIV_S && !sum_i) : (eff_priv_i != PRIV_S);
    case (acc_i)
      ACC_FETCH: bad_perm = !x;
      ACC_LOAD:  bad_perm = !(r || (mxr_i && x));
      default:   bad_perm = !(r && w);
    endcase
    misalign   = |(ppn & low_mask);
    leaf_bad_o = bad_basic || bad_priv || bad_perm || misalign;
    need_ad_o  = !a || (store && !d);
    upd_pte_o  = pte_i;
    upd_pte_o[B_A] = 1'b1;
    if (store) upd_pte_o[B_D] = 1'b1;
    paddr_o = {(ppn & ~low_mask) | (vpn & low_mask), vaddr_i[PAGE_BITS-1:0]};
    r_o = r;
    x_o = x;
    w_o = w && (store || d);
  end
endmodule

// File: rtl/sv32_walker.sv
module sv32_walker import sv32_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [1:0]        req_acc_i,
  input  logic [1:0]        req_priv_i,
  input  logic              req_mprv_i,
  input  logic [1:0]        req_mpp_i,
  input  logic              req_sum_i,
  input  logic              req_mxr_i,
  input  logic              req_paging_i,
  input  logic [PPN_W-1:0]  req_root_ppn_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [PA_W-1:0]   mem_addr_o,
  output logic [PTE_W-1:0]  mem_wdata_o,
  output logic [PTE_W-1:0]  mem_cmp_o,
  input  logic              mem_rsp_valid_i,
  input  logic [PTE_W-1:0]  mem_rdata_i,
  input  logic              mem_err_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [3:0]        rsp_cause_o,
  output logic [VA_W-1:0]   rsp_tval_o,
  output logic [PA_W-1:0]   rsp_paddr_o,
  output logic              rsp_r_o,
  output logic              rsp_w_o,
  output logic              rsp_x_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_CAS, ST_DONE} st_e;

  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  st_e              st_q;
  logic [VA_W-1:0]  va_q;
  acc_e             acc_q;
  logic [1:0]       eff_q;
  logic             sum_q, mxr_q;
  logic [PPN_W-1:0] root_q, base_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PTE_W-1:0] old_q, new_q;

  logic [1:0]       eff_d;
  logic             bypass_d;
  logic [PTE_W-1:0] pte_in, upd_pte;
  logic             is_ptr, leaf_bad, need_ad, pr, pw, px;
  logic [PA_W-1:0]  leaf_pa;
  logic [IDX_BITS-1:0] idx_lvl [LEVELS];

  sv32_mode_sel i_mode (
    .priv_i    (req_priv_i),
    .acc_i     (acc_e'(req_acc_i)),
    .mprv_i    (req_mprv_i),
    .mpp_i     (req_mpp_i),
    .paging_i  (req_paging_i),
    .eff_priv_o(eff_d),
    .bypass_o  (bypass_d)
  );

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_lvl[g] = va_q[PAGE_BITS + g*IDX_BITS +: IDX_BITS];
  end

  // during the swap the evaluated entry is the one already read
  assign pte_in = (st_q == ST_CAS) ? old_q : mem_rdata_i;

  sv32_pte_eval i_eval (
    .pte_i     (pte_in),
    .lvl_i     (lvl_q),
    .eff_priv_i(eff_q),
    .acc_i     (acc_q),
    .sum_i     (sum_q),
    .mxr_i     (mxr_q),
    .vaddr_i   (va_q),
    .is_ptr_o  (is_ptr),
    .leaf_bad_o(leaf_bad),
    .need_ad_o (need_ad),
    .upd_pte_o (upd_pte),
    .paddr_o   (leaf_pa),
    .r_o       (pr),
    .w_o       (pw),
    .x_o       (px)
  );

  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q == ST_READ) || (st_q == ST_CAS);
  assign mem_we_o    = (st_q == ST_CAS);
  assign mem_addr_o  = {base_q, {PAGE_BITS{1'b0}}}
                     + (PA_W'(idx_lvl[lvl_q]) << PTE_SH);
  assign mem_wdata_o = new_q;
  assign mem_cmp_o   = old_q;
  assign rsp_valid_o = (st_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      va_q   <= '0;
      acc_q  <= ACC_FETCH;
      eff_q  <= PRIV_M;
      sum_q  <= 1'b0;
      mxr_q  <= 1'b0;
      root_q <= '0;
      base_q <= '0;
      lvl_q  <= '0;
      old_q  <= '0;
      new_q  <= '0;
      rsp_fault_o <= 1'b0;
      rsp_cause_o <= '0;
      rsp_tval_o  <= '0;
      rsp_paddr_o <= '0;
      rsp_r_o <= 1'b0;
      rsp_w_o <= 1'b0;
      rsp_x_o <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q   <= req_vaddr_i;
          acc_q  <= acc_e'(req_acc_i);
          eff_q  <= eff_d;
          sum_q  <= req_sum_i;
          mxr_q  <= req_mxr_i;
          root_q <= req_root_ppn_i;
          base_q <= req_root_ppn_i;
          lvl_q  <= TOP_LVL;
          if (bypass_d) begin
            rsp_fault_o <= 1'b0;
            rsp_cause_o <= '0;
            rsp_tval_o  <= '0;
            rsp_paddr_o <= PA_W'(req_vaddr_i);
            {rsp_r_o, rsp_w_o, rsp_x_o} <= 3'b111;
            st_q <= ST_DONE;
          end else begin
            st_q <= ST_READ;
          end
        end
        ST_READ: if (mem_rsp_valid_i) begin
          if (mem_err_i) begin
            rsp_fault_o <= 1'b1;
            rsp_cause_o <= fault_cause(acc_q, 1'b0);
            rsp_tval_o  <= va_q;
            rsp_paddr_o <= '0;
            {rsp_r_o, rsp_w_o, rsp_x_o} <= 3'b000;
            st_q <= ST_DONE;
          end else if (is_ptr && lvl_q != '0) begin
            base_q <= mem_rdata_i[PPN_LSB +: PPN_W];
            lvl_q  <= lvl_q - 1'b1;
          end else if (is_ptr || leaf_bad) begin
            rsp_fault_o <= 1'b1;
            rsp_cause_o <= fault_cause(acc_q, 1'b1);
            rsp_tval_o  <= va_q;
            rsp_paddr_o <= '0;
            {rsp_r_o, rsp_w_o, rsp_x_o} <= 3'b000;
            st_q <= ST_DONE;
          end else if (need_ad) begin
            old_q <= mem_rdata_i;
            new_q <= upd_pte;
            st_q  <= ST_CAS;
          end else begin
            rsp_fault_o <= 1'b0;
            rsp_cause_o <= '0;
            rsp_tval_o  <= '0;
            rsp_paddr_o <= leaf_pa;
            {rsp_r_o, rsp_w_o, rsp_x_o} <= {pr, pw, px};
            st_q <= ST_DONE;
          end
        end
        ST_CAS: if (mem_rsp_valid_i) begin
          if (mem_err_i) begin
            rsp_fault_o <= 1'b1;
            rsp_cause_o <= fault_cause(acc_q, 1'b1);
            rsp_tval_o  <= va_q;
            rsp_paddr_o <= '0;
            {rsp_r_o, rsp_w_o, rsp_x_o} <= 3'b000;
            st_q <= ST_DONE;
          end else if (mem_rdata_i != old_q) begin
            base_q <= root_q;
            lvl_q  <= TOP_LVL;
            st_q   <= ST_READ;
          end else begin
            rsp_fault_o <= 1'b0;
            rsp_cause_o <= '0;
            rsp_tval_o  <= '0;
            rsp_paddr_o <= leaf_pa;
            {rsp_r_o, rsp_w_o, rsp_x_o} <= {pr, pw, px};
            st_q <= ST_DONE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sv32_walker_chk.sv
module sv32_walker_chk import sv32_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [VA_W-1:0]   req_vaddr_i,
  input logic [1:0]        req_acc_i,
  input logic [1:0]        req_priv_i,
  input logic              req_mprv_i,
  input logic [1:0]        req_mpp_i,
  input logic              req_sum_i,
  input logic              req_mxr_i,
  input logic              req_paging_i,
  input logic [PPN_W-1:0]  req_root_ppn_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [PA_W-1:0]   mem_addr_o,
  input logic [PTE_W-1:0]  mem_wdata_o,
  input logic [PTE_W-1:0]  mem_cmp_o,
  input logic              mem_rsp_valid_i,
  input logic [PTE_W-1:0]  mem_rdata_i,
  input logic              mem_err_i,
  input logic              rsp_valid_o,
  input logic              rsp_fault_o,
  input logic [3:0]        rsp_cause_o,
  input logic [VA_W-1:0]   rsp_tval_o,
  input logic [PA_W-1:0]   rsp_paddr_o,
  input logic              rsp_r_o,
  input logic              rsp_w_o,
  input logic              rsp_x_o
);
  localparam logic [PTE_W-1:0] AD_MASK = (PTE_W'(1) << B_A) | (PTE_W'(1) << B_D);

  a_r12_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r12_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rsp_valid_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  a_r12_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || rsp_valid_o) |-> !req_ready_o);

  a_r7_swap_sets_only_ad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> ((mem_wdata_o & ~mem_cmp_o & ~AD_MASK) == '0)
      && ((mem_wdata_o & mem_cmp_o) == mem_cmp_o) && mem_wdata_o[B_A]
      && (mem_wdata_o != mem_cmp_o));

  a_r11_fault_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> rsp_paddr_o == '0 && !rsp_r_o && !rsp_w_o && !rsp_x_o
      && (rsp_cause_o inside {4'd1, 4'd5, 4'd7, 4'd12, 4'd13, 4'd15}));

  a_r10_write_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_w_o |-> rsp_r_o);
endmodule

bind sv32_walker sv32_walker_chk i_chk (.*);

// File: tb/test_sv32_walker.sv
`timescale 1ns/1ps
module test_sv32_walker;
  import sv32_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready;
  logic [31:0] req_vaddr = 0;
  logic [1:0] req_acc = 0, req_priv = 0, req_mpp = 0;
  logic req_mprv = 0, req_sum = 0, req_mxr = 0, req_paging = 0;
  logic [21:0] req_root = 0;
  logic mem_req, mem_we, mem_rsp_valid = 0, mem_err = 0;
  logic [33:0] mem_addr;
  logic [31:0] mem_wdata, mem_cmp, mem_rdata = 0;
  logic rsp_valid, rsp_fault, rsp_r, rsp_w, rsp_x;
  logic [3:0] rsp_cause;
  logic [31:0] rsp_tval;
  logic [33:0] rsp_paddr;

  always #2.5 clk = ~clk;

  sv32_walker i_sv32_walker (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .req_acc_i(req_acc), .req_priv_i(req_priv), .req_mprv_i(req_mprv),
    .req_mpp_i(req_mpp), .req_sum_i(req_sum), .req_mxr_i(req_mxr),
    .req_paging_i(req_paging), .req_root_ppn_i(req_root),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_cmp_o(mem_cmp), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rdata_i(mem_rdata), .mem_err_i(mem_err),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_cause_o(rsp_cause),
    .rsp_tval_o(rsp_tval), .rsp_paddr_o(rsp_paddr),
    .rsp_r_o(rsp_r), .rsp_w_o(rsp_w), .rsp_x_o(rsp_x)
  );

  int n_chk = 0, n_fail = 0;
  bit ended = 0;

  task automatic chk(bit ok, string req, string what, logic [79:0] act, logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    finish_run();
  end

  // memory model
  localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08,
                         FU = 8'h10, FA = 8'h40, FD = 8'h80;
  localparam logic [31:0] INTF = 32'h20;
  logic [31:0] mem [longint];
  longint rd_err_w = -1, cas_err_w = -1;
  bit interfere = 0;
  int lat = 0, wait_n = 0;

  typedef struct {logic [33:0] addr; logic we; logic [31:0] wdata; logic [31:0] cmp;} acc_t;
  acc_t exp_q[$];

  function automatic logic [31:0] mk(logic [21:0] ppn, logic [7:0] fl);
    return {ppn, 2'b00, fl};
  endfunction
  function automatic longint wix(logic [21:0] ppn, int idx);
    return longint'(ppn) * 1024 + idx;
  endfunction
  function automatic logic [31:0] rd(longint w);
    return mem.exists(w) ? mem[w] : 32'h0;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid = 0; mem_err = 0; wait_n = 0;
    end else if (mem_rsp_valid) begin
      mem_rsp_valid = 0; mem_err = 0;
    end else if (mem_req) begin
      if (wait_n < lat) wait_n++;
      else begin
        longint w;
        wait_n = 0;
        w = longint'(mem_addr >> 2);
        if (exp_q.size() == 0) chk(0, "R3", "unexpected access", 80'(mem_addr), 80'(0));
        else begin
          acc_t e;
          e = exp_q.pop_front();
          chk(mem_addr == e.addr && mem_we == e.we &&
              (!mem_we || (mem_wdata == e.wdata && mem_cmp == e.cmp)),
              e.we ? "R7" : "R3", "access",
              {11'(0), mem_we, mem_addr, mem_wdata, 2'b0},
              {11'(0), e.we, e.addr, e.wdata, 2'b0});
        end
        if (!mem_we) begin
          mem_err = (w == rd_err_w);
          mem_rdata = rd(w);
        end else if (w == cas_err_w) begin
          mem_err = 1; mem_rdata = 0;
        end else begin
          if (interfere) begin mem[w] = rd(w) ^ INTF; interfere = 0; end
          mem_rdata = rd(w);
          if (mem_rdata == mem_cmp) mem[w] = mem_wdata;
        end
        mem_rsp_valid = 1;
      end
    end
  end

  // behavioural reference of one translation
  logic e_fault, e_r, e_w, e_x, e_byp;
  logic [3:0] e_cause;
  logic [31:0] e_tval;
  logic [33:0] e_pa;

  task automatic ref_walk(logic [31:0] va, logic [1:0] acc, logic [1:0] priv, logic mprv,
                          logic [1:0] mpp, logic sum, logic mxr, logic pg, logic [21:0] root);
    logic [31:0] refm [longint];
    logic [1:0] eff;
    bit intf, done, restart;
    refm = mem;
    intf = interfere;
    eff = (priv == 2'd3 && acc != 2'd0 && mprv) ? mpp : priv;
    e_fault = 0; e_cause = 0; e_tval = 0; e_pa = 0; {e_r, e_w, e_x} = 0;
    e_byp = (eff == 2'd3) || !pg;
    if (e_byp) begin
      e_pa = {2'b00, va}; {e_r, e_w, e_x} = 3'b111;
      return;
    end
    done = 0;
    while (!done) begin
      logic [21:0] base;
      base = root;
      restart = 0;
      for (int lvl = 1; lvl >= 0; lvl--) begin
        logic [9:0] idx;
        logic [33:0] a;
        logic [31:0] p, n;
        logic v, r, w, x, u, bad;
        idx = (lvl == 1) ? va[31:22] : va[21:12];
        a = {base, 12'h0} + {idx, 2'b00};
        exp_q.push_back('{a, 1'b0, 32'h0, 32'h0});
        if (longint'(a >> 2) == rd_err_w) begin
          e_fault = 1; e_cause = (acc == 0) ? 4'd1 : (acc == 1) ? 4'd5 : 4'd7;
          done = 1; break;
        end
        p = refm.exists(longint'(a >> 2)) ? refm[longint'(a >> 2)] : 32'h0;
        {u, x, w, r, v} = p[4:0];
        if (v && !r && !w && !x && lvl == 1) begin base = p[31:10]; continue; end
        bad = (v && !r && !w && !x) || !v || (w && !r);
        if (u) bad |= (eff == 2'd1 && !sum); else bad |= (eff != 2'd1);
        if (acc == 0) bad |= !x;
        else if (acc == 1) bad |= !(r || (mxr && x));
        else bad |= !(r && w);
        if (lvl == 1 && p[19:10] != 0) bad = 1;
        if (bad) begin
          e_fault = 1; e_cause = (acc == 0) ? 4'd12 : (acc == 1) ? 4'd13 : 4'd15;
          done = 1; break;
        end
        if (!p[6] || (acc == 2 && !p[7])) begin
          n = p | 32'h40 | ((acc == 2) ? 32'h80 : 32'h0);
          exp_q.push_back('{a, 1'b1, n, p});
          if (longint'(a >> 2) == cas_err_w) begin
            e_fault = 1; e_cause = (acc == 0) ? 4'd12 : (acc == 1) ? 4'd13 : 4'd15;
            done = 1; break;
          end
          if (intf) begin refm[longint'(a >> 2)] = p ^ INTF; intf = 0; restart = 1; break; end
          refm[longint'(a >> 2)] = n;
          p = n;
        end
        e_pa = {p[31:20], (lvl == 1) ? va[21:12] : p[19:10], va[11:0]};
        e_r = p[1]; e_x = p[3]; e_w = p[2] && (acc == 2 || p[7]);
        done = 1; break;
      end
      if (!restart && !done) begin
        e_fault = 1; e_cause = (acc == 0) ? 4'd12 : (acc == 1) ? 4'd13 : 4'd15; done = 1;
      end
    end
    if (e_fault) begin e_tval = va; e_pa = 0; {e_r, e_w, e_x} = 0; end
  endtask

  task automatic run(string req, logic [31:0] va, logic [1:0] acc, logic [1:0] priv,
                     logic mprv, logic [1:0] mpp, logic sum, logic mxr, logic pg);
    int cnt;
    ref_walk(va, acc, priv, mprv, mpp, sum, mxr, pg, 22'h100);
    req_vaddr = va; req_acc = acc; req_priv = priv; req_mprv = mprv; req_mpp = mpp;
    req_sum = sum; req_mxr = mxr; req_paging = pg; req_root = 22'h100;
    req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (e_byp) chk(rsp_valid == 1'b1, "R2", "bypass latency", 80'(rsp_valid), 80'(1));
    cnt = 0;
    while (!rsp_valid && cnt < 400) begin @(negedge clk); cnt++; end
    chk(rsp_valid && {rsp_fault, rsp_cause, rsp_tval, rsp_paddr, rsp_r, rsp_w, rsp_x} ==
        {e_fault, e_cause, e_tval, e_pa, e_r, e_w, e_x}, req, "result",
        {6'(0), rsp_fault, rsp_cause, rsp_tval, rsp_paddr, rsp_r, rsp_w, rsp_x},
        {6'(0), e_fault, e_cause, e_tval, e_pa, e_r, e_w, e_x});
    chk(exp_q.size() == 0, "R3", "accesses left", 80'(exp_q.size()), 80'(0));
    exp_q.delete();
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R12", "pulse/ready", {78'(0), rsp_valid, req_ready}, 80'(1));
  endtask

  localparam logic [1:0] U = 2'd0, S = 2'd1, M = 2'd3;
  localparam logic [1:0] F = 2'd0, L = 2'd1, ST = 2'd2;

  function automatic logic [31:0] va(int v1, int v0, int off);
    return {10'(v1), 10'(v0), 12'(off)};
  endfunction

  initial begin
    mem[wix(22'h100, 1)] = mk(22'h200, FV);
    mem[wix(22'h200, 0)] = mk(22'h300, FV|FR|FW|FX|FA|FD);
    mem[wix(22'h200, 1)] = mk(22'h301, FV|FR|FA);
    mem[wix(22'h200, 2)] = mk(22'h302, FV|FR|FW);
    mem[wix(22'h200, 3)] = mk(22'h303, FV|FR|FW|FA);
    mem[wix(22'h200, 4)] = mk(22'h304, FV|FX|FU|FA);
    mem[wix(22'h200, 6)] = mk(22'h306, FV|FW|FA);
    mem[wix(22'h200, 7)] = mk(22'h307, FV|FX|FA);
    mem[wix(22'h200, 8)] = mk(22'h308, FV|FR|FW|FA);
    mem[wix(22'h200, 9)] = mk(22'h309, FV|FR|FW);
    mem[wix(22'h100, 2)] = mk(22'h1400, FV|FR|FW|FX|FA|FD);
    mem[wix(22'h100, 3)] = mk(22'h1401, FV|FR|FW|FX|FA|FD);
    mem[wix(22'h100, 4)] = mk(22'h201, FV);
    mem[wix(22'h201, 0)] = mk(22'h205, FV);
    mem[wix(22'h100, 5)] = mk(22'h202, FV);
    rd_err_w  = wix(22'h202, 0);
    cas_err_w = wix(22'h200, 8);

    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "R12", "reset state",
        {77'(0), req_ready, rsp_valid, mem_req}, 80'(4));
    rst_n = 1;
    @(negedge clk);

    run("R2", 32'hdead_beef, L, M, 0, 0, 0, 0, 1);             // machine bypass
    run("R2", 32'h1234_5678, ST, S, 0, 0, 0, 0, 0);            // paging off
    run("R1", va(1, 0, 12'h456), L, M, 1, S, 0, 0, 1);         // substituted to S
    run("R1", va(1, 0, 12'h456), F, M, 1, S, 0, 0, 1);         // fetch keeps M
    run("R1", va(1, 0, 12'h456), ST, M, 1, M, 0, 0, 1);        // mpp=M bypass
    run("R3", va(1, 0, 12'habc), L, S, 0, 0, 0, 0, 1);
    lat = 2;
    run("R10", va(1, 0, 12'h010), ST, S, 0, 0, 0, 0, 1);
    run("R6", va(1, 1, 12'h020), F, S, 0, 0, 0, 0, 1);         // no X
    run("R10", va(1, 1, 12'h020), L, S, 0, 0, 0, 0, 1);        // w=0
    lat = 0;
    run("R7", va(1, 2, 12'h030), L, S, 0, 0, 0, 0, 1);         // set A
    run("R7", va(1, 2, 12'h030), L, S, 0, 0, 0, 0, 1);         // no swap now
    run("R10", va(1, 3, 12'h040), L, S, 0, 0, 0, 0, 1);        // clean, w=0
    run("R7", va(1, 3, 12'h040), ST, S, 0, 0, 0, 0, 1);        // set D
    run("R10", va(1, 3, 12'h040), L, S, 0, 0, 0, 0, 1);        // dirty now, w=1
    run("R5", va(1, 4, 0), F, U, 0, 0, 0, 0, 1);
    run("R5", va(1, 4, 0), F, S, 0, 0, 0, 0, 1);               // fault no SUM
    run("R5", va(1, 4, 0), F, S, 0, 0, 1, 0, 1);               // SUM allows
    run("R5", va(1, 0, 0), L, U, 0, 0, 0, 0, 1);               // supervisor page
    run("R4", va(1, 5, 0), L, S, 0, 0, 0, 0, 1);               // invalid
    run("R4", va(1, 6, 0), ST, S, 0, 0, 0, 0, 1);              // W without R
    run("R6", va(1, 7, 0), L, S, 0, 0, 0, 0, 1);               // X only, no MXR
    run("R6", va(1, 7, 0), L, S, 0, 0, 0, 1, 1);               // MXR
    run("R6", va(1, 1, 0), ST, S, 0, 0, 0, 0, 1);              // store to R-only
    run("R8", va(1, 8, 0), ST, S, 0, 0, 0, 0, 1);              // swap error
    interfere = 1;
    run("R8", va(1, 9, 12'h777), ST, S, 0, 0, 0, 0, 1);        // restart
    run("R9", va(2, 10'h155, 12'h123), F, S, 0, 0, 0, 0, 1);   // superpage
    run("R9", va(3, 10'h155, 12'h123), L, S, 0, 0, 0, 0, 1);   // misaligned
    run("R4", va(4, 0, 0), L, S, 0, 0, 0, 0, 1);               // pointer at last level
    run("R11", va(5, 0, 0), L, S, 0, 0, 0, 0, 1);              // access fault 5
    run("R11", va(5, 0, 0), F, S, 0, 0, 0, 0, 1);              // access fault 1
    run("R11", va(0, 0, 0), ST, S, 0, 0, 0, 0, 1);             // page fault 15
    finish_run();
  end
endmodule